// File: doc/BRIEF.md
# Segmented Real-Mode Address Generator

This block turns a segment-plus-offset memory reference into a 20-bit physical address for a 16-bit processor that uses segmentation. It holds six 16-bit segment registers, which a write port loads. On every request it picks one of them from three inputs: the kind of access, whether the address is based on the BP register, and an optional override prefix. It then adds the chosen segment, shifted up by four bits, to a 16-bit offset. The result is registered and returned one clock after the request strobe, together with the index of the segment that was used.

Segment choice follows fixed rules. Instruction fetches always take the code segment. String destinations always take the extra segment. In both cases any override is ignored. Stack accesses and BP-based data default to the stack segment. String sources and all other data default to the data segment, and a valid override may replace the default.

A two-state machine controls the response. `ST_IDLE` means that no response is being presented. `ST_RESP` means that `rsp_valid` is high and the address and segment outputs hold the result of the previous cycle's request. The transition taken at each clock depends only on `req_valid`. When `req_valid` is high, the machine moves to `ST_RESP`, from either state. When `req_valid` is low, it moves to `ST_IDLE`, from either state. Reset puts the machine in `ST_IDLE`.

Top module: `seg_addr_gen`

Encodings used throughout:
- Segment indices: 0 code, 1 data, 2 stack, 3 extra, 4 auxiliary A, 5 auxiliary B. Indices 6 and 7 are not registers.
- Access kinds (`req_kind`): 0 fetch, 1 stack, 2 BP-based data, 3 string source, 4 string destination, 5 other data. Codes 6 and 7 are treated as other data.

## Requirements
- R1: While reset is asserted, and after it is released, all six segment registers hold 0. `rsp_valid` is 0, `rsp_addr` is 0 and `rsp_seg` is 0.
- R2: One clock after a cycle with `req_valid`=1, `rsp_valid` is 1 and `rsp_addr` equals ({segment, 4'b0000} + offset) modulo 2^20. For example, 06EFh:9234h gives 10124h, and 06EFh:1234h, 0812h:0004h and 0000h:8124h each give 08124h.
- R3: A sum at or above 1 MiB wraps: its carry out of bit 19 is dropped. For example, FFFFh:FFFFh gives 0FFEFh.
- R4: Kind 0 (fetch) always uses segment 0 (code), even when a valid override is given.
- R5: Kind 1 (stack) uses segment 2 (stack) when no valid override is given.
- R6: Kind 2 (BP-based data) uses segment 2 (stack) when no valid override is given.
- R7: Kind 3 (string source) uses segment 1 (data) by default. A valid override with an index from 0 to 5 selects that segment instead.
- R8: Kind 4 (string destination) always uses segment 3 (extra), even when a valid override is given.
- R9: Kind 5, and the unused codes 6 and 7, use segment 1 (data) by default. A valid override with an index from 0 to 5 selects that segment instead.
- R10: An override with `ovr_valid`=1 but index 6 or 7 is ignored, and the default segment for the kind is used.
- R11: A write with `wr_en`=1 and `wr_idx` from 0 to 5 loads that register. A request issued in the same cycle as the write sees the old value, and a request issued in the next cycle sees the new value. A write to index 6 or 7 changes no register.
- R12: `rsp_seg` reports the index of the segment used for the response. `rsp_valid` is 0 one clock after a cycle with `req_valid`=0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Segment register write strobe |
| wr_idx | input | 3 | Index of the segment register to write |
| wr_data | input | 16 | Value to write |
| req_valid | input | 1 | Request strobe |
| req_kind | input | 3 | Access kind code |
| req_offset | input | 16 | Offset within the segment |
| ovr_valid | input | 1 | Override prefix present |
| ovr_idx | input | 3 | Segment index requested by the override |
| rsp_valid | output | 1 | Response valid, one clock after `req_valid` |
| rsp_addr | output | 20 | Physical address |
| rsp_seg | output | 3 | Index of the segment used |

## Verification
Some properties are checked on every cycle by assertions:
- Fetches resolve to the code segment and string destinations resolve to the extra segment, whatever override is presented.
- A request strobe is always followed by exactly one valid response.
- The low nibble of the address always equals the low nibble of the offset.
- A register that is not the target of a valid write keeps its value.

Other behaviour can only be shown by the bench's scenarios:
- Arithmetic with real carries, such as the aliasing examples and the 1 MiB wrap.
- The default segment for each kind, and overrides to each of the six registers.
- Rejection of override indices 6 and 7.
- The one-cycle delay before a written segment value becomes visible to requests.

// File: rtl/seg_agu_pkg.sv
package seg_agu_pkg;

    // Segment register indices
    typedef enum logic [2:0] {
        SEG_CODE  = 3'd0,
        SEG_DATA  = 3'd1,
        SEG_STACK = 3'd2,
        SEG_EXTRA = 3'd3,
        SEG_AUXA  = 3'd4,
        SEG_AUXB  = 3'd5
    } seg_id_e;

    // Access kind codes; 6 and 7 behave as other data
    typedef enum logic [2:0] {
        K_FETCH   = 3'd0,
        K_STACK   = 3'd1,
        K_BPDATA  = 3'd2,
        K_STR_SRC = 3'd3,
        K_STR_DST = 3'd4,
        K_OTHER   = 3'd5
    } acc_kind_e;

    // Response sequencer states
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RESP = 1'b1
    } rsp_state_e;

endpackage

// File: rtl/seg_agu_segfile.sv
module seg_agu_segfile #(
    parameter int SEG_W   = 16,
    parameter int NUM_SEG = 6,
    parameter int IDX_W   = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [SEG_W-1:0] wr_data,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [SEG_W-1:0] rd_data
);

    logic [SEG_W-1:0] regs [NUM_SEG];

    for (genvar g = 0; g < NUM_SEG; g++) begin : g_seg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                regs[g] <= '0;
            end else if (wr_en && (wr_idx == IDX_W'(g))) begin
                regs[g] <= wr_data;
            end
        end

        // R11: a register that is not written keeps its value
        assert_untouched_stable_R11: assert property (
            @(posedge clk) disable iff (!rst_n)
            !(wr_en && (wr_idx == IDX_W'(g))) |=> $stable(regs[g])
        );
    end

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NUM_SEG; i++) begin
            if (rd_idx == IDX_W'(i)) begin
                rd_data = regs[i];
            end
        end
    end

endmodule

// File: rtl/seg_agu_select.sv
module seg_agu_select
    import seg_agu_pkg::*;
#(
    parameter int NUM_SEG = 6,
    parameter int IDX_W   = 3
) (
    input  logic [2:0]       kind,
    input  logic             ovr_valid,
    input  logic [IDX_W-1:0] ovr_idx,
    output logic [IDX_W-1:0] seg_idx
);

    logic ovr_ok;
    assign ovr_ok = ovr_valid && (ovr_idx < IDX_W'(NUM_SEG));

    always_comb begin
        unique case (kind)
            K_FETCH:   seg_idx = IDX_W'(SEG_CODE);
            K_STR_DST: seg_idx = IDX_W'(SEG_EXTRA);
            K_STACK,
            K_BPDATA:  seg_idx = ovr_ok ? ovr_idx : IDX_W'(SEG_STACK);
            default:   seg_idx = ovr_ok ? ovr_idx : IDX_W'(SEG_DATA);
        endcase
    end

endmodule

// File: rtl/seg_agu_adder.sv
module seg_agu_adder #(
    parameter int SEG_W = 16,
    parameter int OFF_W = 16,
    parameter int SHIFT = 4
) (
    input  logic [SEG_W-1:0]       seg,
    input  logic [OFF_W-1:0]       off,
    output logic [SEG_W+SHIFT-1:0] addr
);

    localparam int ADDR_W = SEG_W + SHIFT;

    // The carry out of the top bit is dropped, so the address wraps
    assign addr = {seg, {SHIFT{1'b0}}} + {{(ADDR_W-OFF_W){1'b0}}, off};

endmodule

// File: rtl/seg_addr_gen.sv
module seg_addr_gen
    import seg_agu_pkg::*;
#(
    parameter int SEG_W   = 16,
    parameter int OFF_W   = 16,
    parameter int SHIFT   = 4,
    parameter int NUM_SEG = 6,
    parameter int IDX_W   = 3
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic [IDX_W-1:0]       wr_idx,
    input  logic [SEG_W-1:0]       wr_data,
    input  logic                   req_valid,
    input  logic [2:0]             req_kind,
    input  logic [OFF_W-1:0]       req_offset,
    input  logic                   ovr_valid,
    input  logic [IDX_W-1:0]       ovr_idx,
    output logic                   rsp_valid,
    output logic [SEG_W+SHIFT-1:0] rsp_addr,
    output logic [IDX_W-1:0]       rsp_seg
);

    localparam int ADDR_W = SEG_W + SHIFT;

    rsp_state_e       state, state_nx;
    logic [IDX_W-1:0] sel_idx;
    logic [SEG_W-1:0] sel_seg;
    logic [ADDR_W-1:0] sum_addr;

    seg_agu_select #(.NUM_SEG(NUM_SEG), .IDX_W(IDX_W)) u_select (
        .kind      (req_kind),
        .ovr_valid (ovr_valid),
        .ovr_idx   (ovr_idx),
        .seg_idx   (sel_idx)
    );

    seg_agu_segfile #(.SEG_W(SEG_W), .NUM_SEG(NUM_SEG), .IDX_W(IDX_W)) u_segfile (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .wr_data (wr_data),
        .rd_idx  (sel_idx),
        .rd_data (sel_seg)
    );

    seg_agu_adder #(.SEG_W(SEG_W), .OFF_W(OFF_W), .SHIFT(SHIFT)) u_adder (
        .seg  (sel_seg),
        .off  (req_offset),
        .addr (sum_addr)
    );

    // Next-state logic
    always_comb begin
        unique case (state)
            ST_IDLE: state_nx = req_valid ? ST_RESP : ST_IDLE;
            ST_RESP: state_nx = req_valid ? ST_RESP : ST_IDLE;
            default: state_nx = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // Output registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_addr <= '0;
            rsp_seg  <= '0;
        end else if (req_valid) begin
            rsp_addr <= sum_addr;
            rsp_seg  <= sel_idx;
        end
    end

    assign rsp_valid = (state == ST_RESP);

    // R4: a fetch always resolves to the code segment
    assert_fetch_code_R4: assert property (
        @(posedge clk) disable iff (!rst_n)
        (req_valid && req_kind == K_FETCH) |=> (rsp_seg == IDX_W'(SEG_CODE))
    );

    // R8: a string destination always resolves to the extra segment
    assert_strdst_extra_R8: assert property (
        @(posedge clk) disable iff (!rst_n)
        (req_valid && req_kind == K_STR_DST) |=> (rsp_seg == IDX_W'(SEG_EXTRA))
    );

    // R2: a request strobe is followed by a valid response
    assert_req_rsp_R2: assert property (
        @(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid
    );

    // R12: no strobe, no response
    assert_idle_norsp_R12: assert property (
        @(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid
    );

    // R2: the low nibble of the address is the low nibble of the offset
    assert_low_nibble_R2: assert property (
        @(posedge clk) disable iff (!rst_n)
        req_valid |=> (rsp_addr[SHIFT-1:0] == $past(req_offset[SHIFT-1:0]))
    );

endmodule

// File: tb/seg_addr_gen_test.sv
module seg_addr_gen_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_idx = '0;
    logic [15:0] wr_data = '0;
    logic        req_valid = 1'b0;
    logic [2:0]  req_kind = '0;
    logic [15:0] req_offset = '0;
    logic        ovr_valid = 1'b0;
    logic [2:0]  ovr_idx = '0;
    logic        rsp_valid;
    logic [19:0] rsp_addr;
    logic [2:0]  rsp_seg;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        logic [19:0] addr;
        logic [2:0]  seg;
        string       tag;
    } exp_t;

    exp_t        sb[$];
    logic [15:0] shadow [6];

    always #5 clk = ~clk;

    seg_addr_gen uut (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
        .req_valid(req_valid), .req_kind(req_kind), .req_offset(req_offset),
        .ovr_valid(ovr_valid), .ovr_idx(ovr_idx),
        .rsp_valid(rsp_valid), .rsp_addr(rsp_addr), .rsp_seg(rsp_seg)
    );

    function automatic void check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endfunction

    // Monitor: compares each response with the scoreboard head
    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            if (sb.size() == 0) begin
                check(1'b0, "R12 unexpected response", 32'(rsp_addr), 32'h0);
            end else begin
                exp_t e;
                e = sb.pop_front();
                check(rsp_addr == e.addr, {e.tag, " addr"}, 32'(rsp_addr), 32'(e.addr));
                check(rsp_seg == e.seg, {e.tag, " seg (R12)"}, 32'(rsp_seg), 32'(e.seg));
            end
        end
    end

    // Driver: one cycle, optional write and optional request
    task automatic cycle(bit w, logic [2:0] wi, logic [15:0] wd,
                         bit r, logic [2:0] k, logic [15:0] off,
                         bit ov, logic [2:0] oi, logic [2:0] exp_seg, string tag);
        @(negedge clk);
        wr_en = w; wr_idx = wi; wr_data = wd;
        req_valid = r; req_kind = k; req_offset = off;
        ovr_valid = ov; ovr_idx = oi;
        if (r) begin
            exp_t e;
            e.addr = {shadow[exp_seg], 4'h0} + {4'h0, off};
            e.seg  = exp_seg;
            e.tag  = tag;
            sb.push_back(e);
        end
        if (w && wi < 3'd6) shadow[wi] = wd;
    endtask

    task automatic wr(logic [2:0] i, logic [15:0] d);
        cycle(1'b1, i, d, 1'b0, 3'd0, 16'h0, 1'b0, 3'd0, 3'd0, "");
    endtask

    task automatic req(logic [2:0] k, logic [15:0] off, bit ov, logic [2:0] oi,
                       logic [2:0] exp_seg, string tag);
        cycle(1'b0, 3'd0, 16'h0, 1'b1, k, off, ov, oi, exp_seg, tag);
    endtask

    task automatic idle();
        cycle(1'b0, 3'd0, 16'h0, 1'b0, 3'd0, 16'h0, 1'b0, 3'd0, 3'd0, "");
    endtask

    initial begin
        for (int i = 0; i < 6; i++) shadow[i] = 16'h0;
        repeat (3) @(negedge clk);
        check(rsp_valid == 1'b0, "R1 valid in reset", 32'(rsp_valid), 0);
        check(rsp_addr == 20'h0, "R1 addr in reset", 32'(rsp_addr), 0);
        rst_n = 1'b1;
        // R1: registers read as zero after reset
        for (int i = 0; i < 6; i++) req(3'd5, 16'h0, 1'b1, 3'(i), 3'(i), "R1 seg zero");
        idle();
        @(negedge clk);
        check(rsp_valid == 1'b0, "R12 idle", 32'(rsp_valid), 0);

        wr(3'd0, 16'h06EF);
        wr(3'd1, 16'h06EF);
        wr(3'd2, 16'h0812);
        wr(3'd3, 16'h0000);
        wr(3'd4, 16'hFFFF);
        wr(3'd5, 16'h1234);
        // R2 examples
        req(3'd5, 16'h9234, 1'b0, 3'd0, 3'd1, "R2 06EF:9234");
        req(3'd5, 16'h1234, 1'b0, 3'd0, 3'd1, "R2 06EF:1234");
        req(3'd1, 16'h0004, 1'b0, 3'd0, 3'd2, "R5 stack 0812:0004");
        req(3'd3, 16'h8124, 1'b1, 3'd3, 3'd3, "R7 override 0000:8124");
        // R3 wrap
        req(3'd5, 16'hFFFF, 1'b1, 3'd4, 3'd4, "R3 wrap");
        // R4 fetch ignores override
        req(3'd0, 16'h0010, 1'b0, 3'd0, 3'd0, "R4 fetch");
        req(3'd0, 16'h0020, 1'b1, 3'd5, 3'd0, "R4 fetch override ignored");
        // R5 / R6
        req(3'd1, 16'h0100, 1'b0, 3'd0, 3'd2, "R5 stack");
        req(3'd2, 16'h0200, 1'b0, 3'd0, 3'd2, "R6 bp data");
        // R7 string source
        req(3'd3, 16'h0300, 1'b0, 3'd0, 3'd1, "R7 string src");
        req(3'd3, 16'h0301, 1'b1, 3'd5, 3'd5, "R7 string src override");
        // R8 string destination ignores override
        req(3'd4, 16'h0400, 1'b0, 3'd0, 3'd3, "R8 string dst");
        req(3'd4, 16'h0401, 1'b1, 3'd1, 3'd3, "R8 string dst override ignored");
        // R9 other data and unused codes
        req(3'd5, 16'h0500, 1'b0, 3'd0, 3'd1, "R9 other");
        req(3'd6, 16'h0600, 1'b0, 3'd0, 3'd1, "R9 code 6");
        req(3'd7, 16'h0700, 1'b1, 3'd2, 3'd2, "R9 code 7 override");
        req(3'd5, 16'h0501, 1'b1, 3'd0, 3'd0, "R9 override code seg");
        // R10 invalid override index
        req(3'd5, 16'h0800, 1'b1, 3'd6, 3'd1, "R10 ovr 6");
        req(3'd2, 16'h0801, 1'b1, 3'd7, 3'd2, "R10 ovr 7");
        // R11 same-cycle write sees old value, next cycle new
        cycle(1'b1, 3'd1, 16'hA000, 1'b1, 3'd5, 16'h0001, 1'b0, 3'd0, 3'd1, "R11 old value");
        req(3'd5, 16'h0002, 1'b0, 3'd0, 3'd1, "R11 new value");
        // R11 writes to 6 and 7 change nothing
        wr(3'd6, 16'hBEEF);
        wr(3'd7, 16'hCAFE);
        for (int i = 0; i < 6; i++) req(3'd5, 16'h0000, 1'b1, 3'(i), 3'(i), "R11 no write 6/7");
        idle();
        @(negedge clk);
        check(rsp_valid == 1'b0, "R12 idle after burst", 32'(rsp_valid), 0);
        check(sb.size() == 0, "R2 all responses seen", 32'(sb.size()), 0);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule